// File: doc/BRIEF.md
# Successive approximation conversion controller

This block is the digital core of an 8-bit successive approximation converter. It drives a trial code to an external DAC and reads back a one-bit comparator decision. From these it resolves the code one bit per falling clock edge, starting at the most significant bit. An active-low start pulse may arrive at any moment relative to the clock. While the pulse is low, the trial register is held at mid-scale and BUSY is held low. Once the pulse is released, conversion begins after a rising-then-falling clock pair seen through a two-flop synchroniser.

The finished code is copied into an output latch on the edge where BUSY rises. A one-clock done strobe is raised on that same edge. The latch drives an 8-bit bus only while the active-low read enable is low; otherwise the bus is left high impedance. In free-running mode the block restarts by itself on the LSB edge, so one conversion finishes every eight clocks. The first conversion still needs one external start pulse after reset.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset busy_no is 1, done_o is 0, trial_o is 0x00 and the latched result reads 0x00.
- R2: When start_ni falls, busy_no goes low and trial_o becomes 0x80 (bit 7 only) at once, without waiting for a clock edge, and any conversion in progress is abandoned.
- R3: While start_ni stays low, trial_o stays 0x80, busy_no stays low and no done_o pulse is produced.
- R4: Let P be the first rising edge after start_ni rises. The bit 7 decision is taken on the second falling edge after P, and busy_no rises on the ninth falling edge after P.
- R5: On each decision edge the bit under test keeps its 1 when cmp_above_i is 1 and is cleared when it is 0. On the same edge the next lower bit is set. The final code equals the largest code not above the comparator threshold.
- R6: busy_no rises on the edge of the bit 0 decision. done_o is high for exactly one clock from that edge, and the result latch loads on that same edge.
- R7: A new low pulse on start_ni during a conversion restarts it from bit 7. The abandoned conversion produces no done_o pulse and no result.
- R8: data_o carries the latched result while rd_ni is 0 and is high impedance while rd_ni is 1. Reading changes neither the latch nor trial_o.
- R9: With free_run_i high, each completed conversion immediately loads 0x80 and starts the next. busy_no is high for one clock between conversions, so done_o pulses every 8 clocks. Clearing free_run_i lets the current conversion finish and then stops.
- R10: data_o never shows intermediate trial codes. It keeps the previous result until the next done_o.
- R11: With free_run_i high and no start pulse after reset, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock; decisions on falling edges |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_ni | input | 1 | Active-low start, asynchronous to clk_i |
| free_run_i | input | 1 | Restart automatically after each conversion |
| cmp_above_i | input | 1 | Comparator: analogue input at or above trial level |
| rd_ni | input | 1 | Active-low output enable for data_o |
| trial_o | output | 8 | Trial code to the DAC |
| busy_no | output | 1 | Low while a conversion is pending or running |
| done_o | output | 1 | One-clock strobe when a result is latched |
| data_o | output | 8 | Latched result, high impedance when rd_ni is 1 |

## Verification
The bench releases start 3 ns after a rising edge. busy_no is then due 187 ns later: 17 ns to the first rising edge plus 8.5 clocks. The bench compares the measured time exactly. A result is due at the rising edge half a clock after busy_no rises. At that edge the monitor pops the expected code from the scoreboard, and the driver only changes inputs 2 to 3 ns after an edge. In free-running mode, consecutive done_o pulses must be exactly 160 ns apart. The clear caused by start_ni is checked 1 ns after the fall, since it is asynchronous.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_WIDTH = 8;
  localparam int unsigned SAR_SYNC_STAGES = 2;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic start_ni,
  output logic rel_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q <= '0;
        else         q <= start_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q <= '0;
        else         q <= {q[STAGES-2:0], start_ni};
      end
    end
  endgenerate

  assign rel_o = q[STAGES-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             rel_i,
  input  logic             free_run_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_no,
  output logic             done_o,
  output logic             load_o,
  output logic [WIDTH-1:0] final_o
);
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial_q, trial_nxt;
  logic [IW-1:0]    idx_q, idx_dn;
  logic             busy_n_q, run_q, again_q, done_q;
  logic             step, last;

  assign idx_dn = idx_q - 1'b1;
  assign last   = (idx_q == '0);
  // decide when released (or already running), or on a free-run wrap
  assign step   = again_q | (!busy_n_q & (run_q | rel_i));

  always_comb begin
    trial_nxt = trial_q;
    trial_nxt[idx_q] = cmp_i;
    if (!last) trial_nxt[idx_dn] = 1'b1;
  end

  always_ff @(negedge clk_i or negedge rst_ni or negedge start_ni) begin
    if (!rst_ni) begin
      trial_q  <= '0;
      idx_q    <= TOP_IDX;
      busy_n_q <= 1'b1;
      run_q    <= 1'b0;
      again_q  <= 1'b0;
    end else if (!start_ni) begin
      trial_q  <= MSB_ONLY;
      idx_q    <= TOP_IDX;
      busy_n_q <= 1'b0;
      run_q    <= 1'b0;
      again_q  <= 1'b0;
    end else if (step) begin
      if (last) begin
        trial_q  <= free_run_i ? MSB_ONLY : trial_nxt;
        idx_q    <= TOP_IDX;
        busy_n_q <= 1'b1;
        run_q    <= 1'b0;
        again_q  <= free_run_i;
      end else begin
        trial_q  <= trial_nxt;
        idx_q    <= idx_dn;
        busy_n_q <= 1'b0;
        run_q    <= 1'b1;
        again_q  <= 1'b0;
      end
    end
  end

  // strobe survives a start pulse so it always lasts one clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= step & last;
  end

  assign trial_o = trial_q;
  assign busy_no = busy_n_q;
  assign done_o  = done_q;
  assign load_o  = step & last;
  assign final_o = trial_nxt;
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] final_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] result_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (load_i) result_q <= final_i;
  end

  assign result_o = result_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH       = SAR_WIDTH,
  parameter int unsigned SYNC_STAGES = SAR_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             free_run_i,
  input  logic             cmp_above_i,
  input  logic             rd_ni,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_no,
  output logic             done_o,
  output logic [WIDTH-1:0] data_o
);
  logic             clr_n, rel, load;
  logic [WIDTH-1:0] final_code, result;

  assign clr_n = rst_ni & start_ni;

  sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .start_ni(start_ni),
    .rel_o   (rel)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_ni  (start_ni),
    .rel_i     (rel),
    .free_run_i(free_run_i),
    .cmp_i     (cmp_above_i),
    .trial_o   (trial_o),
    .busy_no   (busy_no),
    .done_o    (done_o),
    .load_o    (load),
    .final_o   (final_code)
  );

  sar_result #(.WIDTH(WIDTH)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .final_i (final_code),
    .result_o(result)
  );

  assign data_o = rd_ni ? 'z : result;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_ni,
  input logic             free_run_i,
  input logic             rd_ni,
  input logic [WIDTH-1:0] trial_o,
  input logic             busy_no,
  input logic             done_o,
  input logic [WIDTH-1:0] data_o
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ni |-> (!busy_no && trial_o == MSB_ONLY));

  // R3
  hold_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ni && $past(!start_ni)) |-> !done_o);

  // R5
  one_step_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (start_ni && $past(start_ni) && !busy_no && $past(!busy_no))
      |-> ($countones(trial_o ^ $past(trial_o)) <= 2));

  // R6
  busy_rise_done_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> done_o);

  // R6
  done_pulse_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  free_restart_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (done_o && $past(free_run_i)) |=> !busy_no);

  // R10
  data_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!rd_ni && $past(!rd_ni) && (data_o != $past(data_o))) |-> done_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       free_run = 1'b0;
  logic       rd_n = 1'b0;
  logic [7:0] stim = 8'h00;
  logic       cmp;
  logic [7:0] trial, data;
  logic       busy_n, done;

  int         n_chk = 0;
  int         n_err = 0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  assign cmp = (stim >= trial);

  sar_conv_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_ni   (start_n),
    .free_run_i (free_run),
    .cmp_above_i(cmp),
    .rd_ni      (rd_n),
    .trial_o    (trial),
    .busy_no    (busy_n),
    .done_o     (done),
    .data_o     (data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // scoreboard monitor: result is due half a clock after busy rises
  always @(posedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R7/R11: actual unexpected done data %0h expected no done", data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R5 result", data, e);
      end
    end
  end

  task automatic start_pulse(input int low_clks);
    @(posedge clk); #3 start_n = 1'b0;
    repeat (low_clks) @(posedge clk);
    #3 start_n = 1'b1;
  endtask

  task automatic convert(input logic [7:0] v);
    time t0;
    stim = v;
    exp_q.push_back(v);
    start_pulse(1);
    t0 = $time;
    @(posedge busy_n);
    chk("R4 latency", 32'($time - t0), 32'd187);
    @(posedge clk); #3;
    chk("R6 busy high after", busy_n, 1'b1);
    chk("R6 one result", exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] vals[7] = '{8'hA5, 8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h5A};
    time tl;

    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    #1;
    chk("R1 busy", busy_n, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 trial", trial, 8'h00);
    chk("R1 data", data, 8'h00);

    // R11: free-run armed but never kicked
    free_run = 1'b1;
    repeat (20) @(posedge clk);
    #3;
    chk("R11 busy idle", busy_n, 1'b1);
    chk("R11 trial idle", trial, 8'h00);
    free_run = 1'b0;

    // R4 R5 R6
    foreach (vals[i]) convert(vals[i]);

    // R2 R3 R10: long start pulse
    stim = 8'h33;
    @(posedge clk); #3 start_n = 1'b0;
    #1;
    chk("R2 trial", trial, 8'h80);
    chk("R2 busy", busy_n, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #5;
      chk("R3 trial held", trial, 8'h80);
      chk("R3 busy held", busy_n, 1'b0);
    end
    chk("R10 data kept", data, 8'h5A);
    exp_q.push_back(8'h33);
    @(posedge clk); #3 start_n = 1'b1;
    repeat (4) @(posedge clk);
    #3 chk("R10 data mid conversion", data, 8'h5A);
    @(posedge busy_n);
    @(posedge clk); #3;
    chk("R3 result after hold", exp_q.size(), 0);

    // R7: abandon a conversion part way
    stim = 8'hC3;
    start_pulse(1);
    repeat (4) @(posedge clk);
    #3;
    chk("R7 busy mid", busy_n, 1'b0);
    chk("R10 data mid abort", data, 8'h33);
    stim = 8'h3C;
    exp_q.push_back(8'h3C);
    @(posedge clk); #3 start_n = 1'b0;
    #1 chk("R7 restart trial", trial, 8'h80);
    @(posedge clk); #3 start_n = 1'b1;
    @(posedge busy_n);
    @(posedge clk); #3;
    chk("R7 single result", exp_q.size(), 0);
    chk("R7 data", data, 8'h3C);

    // R8: output enable and non-destructive read
    rd_n = 1'b1;
    #1 chk("R8 high impedance", (data === 8'hzz), 1'b1);
    rd_n = 1'b0;
    #1 chk("R8 read", data, 8'h3C);
    repeat (3) @(posedge clk);
    #3;
    chk("R8 read again", data, 8'h3C);
    chk("R8 trial untouched", trial, 8'h3C);

    // R9: free-running
    free_run = 1'b1;
    stim = 8'h11;
    exp_q.push_back(8'h11);
    start_pulse(1);
    tl = 0;
    for (int k = 0; k < 5; k++) begin
      do @(posedge clk); while (!done);
      if (k > 0) chk("R9 period", 32'($time - tl), 32'd160);
      tl = $time;
      chk("R9 busy gap", busy_n, 1'b1);
      #2;
      stim = 8'h11 + 8'(k * 8'h2F + 8'h06);
      exp_q.push_back(stim);
      if (k == 4) free_run = 1'b0;
      @(negedge clk); #3;
      chk("R9 restarted", busy_n, 1'b0);
    end
    do @(posedge clk); while (!done);
    chk("R9 last period", 32'($time - tl), 32'd160);
    repeat (24) @(posedge clk);
    #3;
    chk("R9 stopped", busy_n, 1'b1);
    chk("R9 queue drained", exp_q.size(), 0);

    finished = 1'b1;
    summary();
  end
endmodule